// File: doc/BRIEF.md
# Reset Strap Option Latch

This block sits between a set of dual-purpose pads and the rest of a physical-layer transceiver. While the synchronous reset is high, every shared pad is an input that carries a configuration level set on the board. On the first clock edge after reset falls, the block stores all pad levels at once and decodes them into the operating configuration. That configuration covers a management address, automatic crossover, receive tri-state, reduced or full media-independent interface selection, auto-negotiation, repeater or node operation, and forced speed and duplex.

After the capture, the pads turn into outputs that carry their run-time signals. The output-enable is raised one clock later, so the block never drives against the strap resistors while they are still being read. When auto-negotiation is enabled by strap, the effective speed and duplex come from the negotiation result inputs, and the forced straps are ignored.

Top module: `strap_latch_top`

## Requirements
- R1: While reset is sampled high, pad_oe is all zeros and pad_out is all zeros from the next clock edge onward.
- R2: On the first clock edge with reset low after reset, every configuration output takes the level of its pad at that edge.
- R3: pad_oe goes to all ones exactly one clock after the capture edge. While pad_oe is high, pad_out equals run_data bit for bit. While pad_oe is low, pad_out is zero.
- R4: After the capture, changes on pad_in have no effect on any configuration output until the next reset.
- R5: mgmt_addr[3:0] is taken from pad_in[3:0], with the same bit order.
- R6: The pad positions and polarities are as follows, with 1 meaning enabled in every case. pad_in[4] is crossover-auto enable. pad_in[5] is receive tri-state enable. pad_in[7] is interface select, with 1 = reduced (RMII) and 0 = MII. pad_in[8] is auto-negotiation enable. pad_in[9] is mode, with 1 = repeater and 0 = node.
- R7: When autoneg_en is 0, eff_speed100 equals the pad_in[10] strap (1 = 100 Mb/s, 0 = 10 Mb/s), and eff_full equals the pad_in[6] strap (1 = full duplex, 0 = half duplex).
- R8: When autoneg_en is 1, eff_speed100 equals an_speed100 and eff_full equals an_full, whatever the speed and duplex straps hold.
- R9: From the first clock edge with reset high until the capture, the configuration shows the pad defaults. These are address 0, crossover 1, tri-state 0, interface 0, auto-negotiation 1 and repeater 0.
- R10: When reset is asserted again after run time, pad_oe returns to zero and the defaults return after one edge. The next release then captures the new pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware/power-on reset |
| pad_in | input | 11 | Levels seen on the shared pads |
| run_data | input | 11 | Run-time signals to drive onto the pads |
| an_speed100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_full | input | 1 | Negotiated duplex, 1 = full |
| pad_out | output | 11 | Data driven to the pads |
| pad_oe | output | 11 | Per-pad output-enable |
| mgmt_addr | output | 4 | Latched management address |
| xover_auto_en | output | 1 | Automatic crossover enable |
| rx_hiz_en | output | 1 | Receive tri-state enable |
| rmii_sel | output | 1 | 1 = reduced interface, 0 = MII |
| autoneg_en | output | 1 | Auto-negotiation enable |
| repeater_mode | output | 1 | 1 = repeater, 0 = node |
| eff_speed100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| eff_full | output | 1 | Effective duplex, 1 = full |

## Verification
The bench builds the block with its default package constants: a 4-bit address and 11 shared pads. At that size, every one of the 2048 strap patterns can be put through a full reset, capture and run sequence. Each pattern also drives a different combination of negotiation inputs. As a result, both settings of the override, every address and every polarity are reached, and so is the inverted-pad hold test.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int ADDR_W  = 4;
    localparam int N_FLAGS = 7;
    localparam int N_PINS  = ADDR_W + N_FLAGS;

    // Pad positions of the single-bit straps
    localparam int IX_XOVER = ADDR_W;
    localparam int IX_HIZ   = ADDR_W + 1;
    localparam int IX_FULL  = ADDR_W + 2;
    localparam int IX_RMII  = ADDR_W + 3;
    localparam int IX_ANEG  = ADDR_W + 4;
    localparam int IX_REP   = ADDR_W + 5;
    localparam int IX_SPD   = ADDR_W + 6;

    typedef enum logic {
        PH_STRAP = 1'b0,
        PH_RUN   = 1'b1
    } pad_phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              xover_en;
        logic              rx_hiz_en;
        logic              rmii_sel;
        logic              aneg_en;
        logic              repeater;
        logic              force_100;
        logic              force_full;
    } strap_cfg_t;

    function automatic logic [N_PINS-1:0] default_straps();
        logic [N_PINS-1:0] v;
        v           = '0;
        v[IX_XOVER] = 1'b1;
        v[IX_FULL]  = 1'b1;
        v[IX_ANEG]  = 1'b1;
        v[IX_SPD]   = 1'b1;
        return v;
    endfunction

    localparam logic [N_PINS-1:0] STRAP_DEFAULT = default_straps();

    function automatic strap_cfg_t decode_straps(input logic [N_PINS-1:0] s);
        strap_cfg_t c;
        c.addr       = s[ADDR_W-1:0];
        c.xover_en   = s[IX_XOVER];
        c.rx_hiz_en  = s[IX_HIZ];
        c.rmii_sel   = s[IX_RMII];
        c.aneg_en    = s[IX_ANEG];
        c.repeater   = s[IX_REP];
        c.force_100  = s[IX_SPD];
        c.force_full = s[IX_FULL];
        return c;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] strap_q,
    output pad_phase_e        phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_STRAP;
            strap_q <= STRAP_DEFAULT;
        end else if (phase == PH_STRAP) begin
            strap_q <= pad_in;
            phase   <= PH_RUN;
        end
    end

endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              captured,
    input  logic [N_PINS-1:0] run_data,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);

    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst) drive_q <= 1'b0;
        else     drive_q <= captured;
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_pad
        assign pad_oe[g]  = drive_q;
        assign pad_out[g] = drive_q & run_data[g];
    end

endmodule

// File: rtl/strap_cfg_resolve.sv
module strap_cfg_resolve
    import strap_pkg::*;
(
    input  logic [N_PINS-1:0] strap_q,
    input  logic              an_speed100,
    input  logic              an_full,
    output strap_cfg_t        cfg,
    output logic              eff_speed100,
    output logic              eff_full
);

    always_comb begin
        cfg          = decode_straps(strap_q);
        eff_speed100 = cfg.aneg_en ? an_speed100 : cfg.force_100;
        eff_full     = cfg.aneg_en ? an_full     : cfg.force_full;
    end

endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] run_data,
    input  logic              an_speed100,
    input  logic              an_full,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [ADDR_W-1:0] mgmt_addr,
    output logic              xover_auto_en,
    output logic              rx_hiz_en,
    output logic              rmii_sel,
    output logic              autoneg_en,
    output logic              repeater_mode,
    output logic              eff_speed100,
    output logic              eff_full
);

    logic [N_PINS-1:0] strap_q;
    pad_phase_e        phase;
    logic              strap_done;
    strap_cfg_t        cfg;

    strap_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .strap_q (strap_q),
        .phase   (phase)
    );

    assign strap_done = (phase == PH_RUN);

    strap_pad_ctrl u_pads (
        .clk      (clk),
        .rst      (rst),
        .captured (strap_done),
        .run_data (run_data),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    strap_cfg_resolve u_resolve (
        .strap_q      (strap_q),
        .an_speed100  (an_speed100),
        .an_full      (an_full),
        .cfg          (cfg),
        .eff_speed100 (eff_speed100),
        .eff_full     (eff_full)
    );

    assign mgmt_addr     = cfg.addr;
    assign xover_auto_en = cfg.xover_en;
    assign rx_hiz_en     = cfg.rx_hiz_en;
    assign rmii_sel      = cfg.rmii_sel;
    assign autoneg_en    = cfg.aneg_en;
    assign repeater_mode = cfg.repeater;

endmodule

// File: rtl/strap_latch_checker.sv
module strap_latch_checker
    import strap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_PINS-1:0] pad_in,
    input logic [N_PINS-1:0] run_data,
    input logic              an_speed100,
    input logic              an_full,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic              xover_auto_en,
    input logic              autoneg_en,
    input logic              eff_speed100,
    input logic              eff_full,
    input logic              strap_done
);

    // R1: reset sampled high leaves all drivers off after the edge
    assert_oe_off_R1: assert property (@(posedge clk) rst |=> (pad_oe == '0 && pad_out == '0));

    // R2 / R5: the capture edge copies the pad levels
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !strap_done |=> (mgmt_addr == $past(pad_in[ADDR_W-1:0]) &&
                         xover_auto_en == $past(pad_in[IX_XOVER]) &&
                         autoneg_en == $past(pad_in[IX_ANEG])));

    // R3: drivers turn on one clock after capture
    assert_oe_delay_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(strap_done) |=> (pad_oe == '1));

    assert_out_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe == '1) |-> (pad_out == run_data));

    // R4: held configuration ignores later pad activity
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        strap_done |=> ($stable(mgmt_addr) && $stable(autoneg_en) && $stable(xover_auto_en)));

    // R8: negotiated result overrides forced straps
    assert_an_override_R8: assert property (@(posedge clk) disable iff (rst)
        autoneg_en |-> (eff_speed100 == an_speed100 && eff_full == an_full));

endmodule

bind strap_latch_top strap_latch_checker u_chk (.*);

// File: tb/strap_latch_top_bench.sv
module strap_latch_top_bench;
    import strap_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_PINS-1:0] pad_in = '0;
    logic [N_PINS-1:0] run_data = '0;
    logic              an_speed100 = 1'b0;
    logic              an_full = 1'b0;
    logic [N_PINS-1:0] pad_out, pad_oe;
    logic [ADDR_W-1:0] mgmt_addr;
    logic              xover_auto_en, rx_hiz_en, rmii_sel, autoneg_en, repeater_mode;
    logic              eff_speed100, eff_full;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    strap_latch_top u_strap_latch_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compute expected configuration from a strap pattern (bit layout of R5/R6/R7)
    task automatic chk_cfg(input string tag, input logic [N_PINS-1:0] s,
                           input logic as, input logic af);
        logic es, ef;
        es = s[8] ? as : s[10];
        ef = s[8] ? af : s[6];
        chk({tag, " R5 addr"}, 32'(mgmt_addr), 32'(s[3:0]));
        chk({tag, " R6 flags"},
            32'({xover_auto_en, rx_hiz_en, rmii_sel, autoneg_en, repeater_mode}),
            32'({s[4], s[5], s[7], s[8], s[9]}));
        if (s[8]) chk({tag, " R8 eff"}, 32'({eff_speed100, eff_full}), 32'({es, ef}));
        else      chk({tag, " R7 eff"}, 32'({eff_speed100, eff_full}), 32'({es, ef}));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N_PINS-1:0] pat;
        repeat (3) @(negedge clk);
        for (int i = 0; i < (1 << N_PINS); i++) begin
            pat = N_PINS'(i);
            // assert reset with the pattern present on the pads
            rst         = 1'b1;
            pad_in      = pat;
            run_data    = ~pat ^ N_PINS'(i >> 3);
            an_speed100 = pat[0] ^ pat[5];
            an_full     = pat[1] ^ pat[9];
            @(negedge clk);
            chk(i == 0 ? "R1 oe in reset" : "R10 oe after reassert", 32'(pad_oe), 32'h0);
            chk("R1 pad_out in reset", 32'(pad_out), 32'h0);
            chk("R9 defaults", 32'({mgmt_addr, xover_auto_en, rx_hiz_en, rmii_sel, autoneg_en, repeater_mode}),
                32'({4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}));
            chk("R9 eff follows an", 32'({eff_speed100, eff_full}), 32'({an_speed100, an_full}));
            rst = 1'b0;
            @(negedge clk); // capture edge passed
            chk_cfg("R2 capture", pat, an_speed100, an_full);
            chk("R3 oe still low at capture", 32'(pad_oe), 32'h0);
            pad_in = ~pat;
            @(negedge clk); // one clock after capture
            chk("R3 oe high", 32'(pad_oe), 32'((1 << N_PINS) - 1));
            chk("R3 pad_out=run_data", 32'(pad_out), 32'(run_data));
            chk_cfg("R4 hold", pat, an_speed100, an_full);
            an_speed100 = ~an_speed100;
            an_full     = ~an_full;
            run_data    = ~run_data;
            @(negedge clk);
            chk_cfg("R4 hold late", pat, an_speed100, an_full);
            chk("R3 pad_out follows", 32'(pad_out), 32'(run_data));
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule